// File: doc/BRIEF.md
# Size and Increment Programmable Memory Copy Engine

This block copies a run of elements from one memory region to another on a single channel. Three settings are programmed separately: the element width, the step applied to the source address after each read, and the step applied to the destination address after each write. Each element is read from the source, held in a small staging FIFO, and then written to the destination. Matching settings give a plain copy. Mismatched settings scatter or gather sub-word data. For example, half-words can be packed into one word, or a byte stream can be spread one byte per word to suit a narrow peripheral. A step of zero lets a fixed location act as a peripheral data register.

A one-cycle start pulse loads the base addresses, the element count and the three settings. The engine drives a synchronous read port, whose data returns one cycle after the request, and a write port with byte enables. It pulses a done signal once the last element has been written.

Top module: `xfer_engine`

## Requirements
- R1: While reset is low, and afterwards until a start is accepted, `busy_o`, `done_o`, `rd_req_o` and `wr_req_o` are all low.
- R2: The step codes for both addresses are 0 = +1 byte, 1 = +2 bytes, 2 = +4 bytes and 3 = no change. Read k uses address src_base + k*step and write k uses address dst_base + k*step.
- R3: The size codes are 0 = byte, 1 = half-word and 2 = word. Code 3 is handled exactly like word.
- R4: A byte element is taken from read-data lane addr[1:0], bits 8*addr[1:0] and up. A half-word element is taken from bits 31:16 when addr[1]=1 and from bits 15:0 otherwise.
- R5: On a write, the byte enables are 4'b0001<<addr[1:0] for a byte, 4'b0011<<(2*addr[1]) for a half-word and 4'b1111 for a word. The element is replicated across all lanes of `wr_data_o`.
- R6: With word size and word steps, the destination becomes an in-order copy of the source words, with each byte in its original lane.
- R7: With half-word size and half-word steps, a count of 2N leaves the same destination image as the word setting with count N, and takes 2N writes.
- R8: Elements are written in read order. Issued reads never exceed completed writes by more than the FIFO depth (4), and no write is issued from an empty FIFO.
- R9: A transfer of N > 0 elements issues exactly N reads and N writes. `done_o` is high for exactly the one cycle after the final write, and `busy_o` is low from that cycle on.
- R10: A start pulse while `busy_o` is high changes neither the transfer in progress nor anything after it.
- R11: A start with count 0 issues no access and raises `done_o` for one cycle, in the cycle after the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only while idle |
| src_base_i | input | AW | Source byte address |
| dst_base_i | input | AW | Destination byte address |
| count_i | input | CW | Number of elements |
| size_i | input | 2 | Element width code |
| src_step_i | input | 2 | Source step code |
| dst_step_i | input | 2 | Destination step code |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | AW | Read byte address |
| rd_data_i | input | 32 | Read word, valid the cycle after the request |
| wr_req_o | output | 1 | Write request |
| wr_addr_o | output | AW | Write byte address |
| wr_data_o | output | 32 | Write word, element replicated across lanes |
| wr_be_o | output | 4 | Write byte enables |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse at completion |

## Verification
The properties rely on two things about the inputs. Memory returns read data exactly one cycle after each request, with no stall. Every address the engine visits is aligned to the element width, so a half-word never straddles lanes 1 and 2 and a word always starts on lane 0. The bench's memory model always answers on the next cycle. Its random generator picks base offsets that are multiples of the element width. Whenever a non-zero step would be smaller than the element, it raises the step to the element width. Source and destination regions are kept apart, so that read order and write order cannot interfere.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int unsigned LANES = 4;

  typedef enum logic [1:0] {
    U_BYTE = 2'd0,
    U_HALF = 2'd1,
    U_WORD = 2'd2,
    U_NONE = 2'd3
  } unit_e;

  function automatic logic [2:0] step_of(logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      2'd2:    return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  // code 3 in the size field behaves as word
  function automatic unit_e norm_size(logic [1:0] code);
    return (code == U_NONE) ? U_WORD : unit_e'(code);
  endfunction
endpackage

// File: rtl/xfer_addr_gen.sv
module xfer_addr_gen #(
  parameter int unsigned AW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic [1:0]    code_i,
  input  logic          adv_i,
  output logic [AW-1:0] addr_o
);
  import xfer_pkg::*;

  logic [AW-1:0] addr_q;
  logic [1:0]    code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      code_q <= 2'd0;
    end else if (load_i) begin
      addr_q <= base_i;
      code_q <= code_i;
    end else if (adv_i) begin
      addr_q <= addr_q + AW'(step_of(code_q));
    end
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/xfer_fifo.sv
module xfer_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     data_i,
  input  logic             pop_i,
  output logic [W-1:0]     data_o,
  output logic             empty_o,
  output logic [LVL_W-1:0] level_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PW-1:0]    wptr_q, rptr_q;
  logic [LVL_W-1:0] level_q;

  function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
    end else begin
      if (push_i) wptr_q <= bump(wptr_q);
      if (pop_i)  rptr_q <= bump(rptr_q);
      case ({push_i, pop_i})
        2'b10:   level_q <= level_q + LVL_W'(1);
        2'b01:   level_q <= level_q - LVL_W'(1);
        default: level_q <= level_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wptr_q] <= data_i;
  end

  assign data_o  = mem_q[rptr_q];
  assign empty_o = (level_q == '0);
  assign level_o = level_q;
endmodule

// File: rtl/xfer_lane_pick.sv
module xfer_lane_pick
  import xfer_pkg::*;
(
  input  logic [8*LANES-1:0] data_i,
  input  logic [1:0]         lane_i,
  input  unit_e              size_i,
  output logic [8*LANES-1:0] elem_o
);
  always_comb begin
    case (size_i)
      U_BYTE:  elem_o = {24'd0, data_i[8*lane_i +: 8]};
      U_HALF:  elem_o = {16'd0, lane_i[1] ? data_i[31:16] : data_i[15:0]};
      default: elem_o = data_i;
    endcase
  end
endmodule

// File: rtl/xfer_lane_place.sv
module xfer_lane_place
  import xfer_pkg::*;
(
  input  logic [8*LANES-1:0] elem_i,
  input  logic [1:0]         lane_i,
  input  unit_e              size_i,
  output logic [8*LANES-1:0] data_o,
  output logic [LANES-1:0]   be_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      case (size_i)
        U_BYTE: begin
          data_o[8*g +: 8] = elem_i[7:0];
          be_o[g]          = (lane_i == 2'(g));
        end
        U_HALF: begin
          data_o[8*g +: 8] = elem_i[8*(g%2) +: 8];
          be_o[g]          = (lane_i[1] == 1'(g/2));
        end
        default: begin
          data_o[8*g +: 8] = elem_i[8*g +: 8];
          be_o[g]          = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/xfer_engine.sv
module xfer_engine
  import xfer_pkg::*;
#(
  parameter int unsigned AW    = 12,
  parameter int unsigned CW    = 8,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned DW    = 8 * LANES,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] src_base_i,
  input  logic [AW-1:0] dst_base_i,
  input  logic [CW-1:0] count_i,
  input  logic [1:0]    size_i,
  input  logic [1:0]    src_step_i,
  input  logic [1:0]    dst_step_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [DW-1:0] rd_data_i,
  output logic          wr_req_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic [3:0]    wr_be_o,
  output logic          busy_o,
  output logic          done_o
);
  logic          run_q, done_q, rd_pend_q;
  logic [1:0]    pend_lane_q;
  unit_e         size_q;
  logic [CW-1:0] rd_left_q, wr_left_q;

  logic             start_go, last_wr;
  logic [DW-1:0]    picked, head;
  logic             fifo_empty;
  logic [LVL_W-1:0] fifo_level;

  assign start_go = start_i && !run_q;

  // reserve a slot for the read whose data is still in flight
  assign rd_req_o = run_q && (rd_left_q != '0) &&
                    (({1'b0, fifo_level} + (LVL_W + 1)'(rd_pend_q)) < (LVL_W + 1)'(DEPTH));
  assign wr_req_o = run_q && !fifo_empty;
  assign last_wr  = wr_req_o && (wr_left_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q       <= 1'b0;
      done_q      <= 1'b0;
      rd_pend_q   <= 1'b0;
      pend_lane_q <= 2'd0;
      size_q      <= U_WORD;
      rd_left_q   <= '0;
      wr_left_q   <= '0;
    end else begin
      done_q      <= 1'b0;
      rd_pend_q   <= rd_req_o;
      pend_lane_q <= rd_addr_o[1:0];
      if (start_go) begin
        size_q    <= norm_size(size_i);
        rd_left_q <= count_i;
        wr_left_q <= count_i;
        if (count_i == '0) done_q <= 1'b1;
        else               run_q  <= 1'b1;
      end else if (run_q) begin
        if (rd_req_o) rd_left_q <= rd_left_q - CW'(1);
        if (wr_req_o) wr_left_q <= wr_left_q - CW'(1);
        if (last_wr) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  xfer_addr_gen #(.AW(AW)) u_src (
    .clk_i, .rst_ni,
    .load_i (start_go),
    .base_i (src_base_i),
    .code_i (src_step_i),
    .adv_i  (rd_req_o),
    .addr_o (rd_addr_o)
  );

  xfer_addr_gen #(.AW(AW)) u_dst (
    .clk_i, .rst_ni,
    .load_i (start_go),
    .base_i (dst_base_i),
    .code_i (dst_step_i),
    .adv_i  (wr_req_o),
    .addr_o (wr_addr_o)
  );

  xfer_lane_pick u_pick (
    .data_i (rd_data_i),
    .lane_i (pend_lane_q),
    .size_i (size_q),
    .elem_o (picked)
  );

  xfer_fifo #(.W(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i  (rd_pend_q),
    .data_i  (picked),
    .pop_i   (wr_req_o),
    .data_o  (head),
    .empty_o (fifo_empty),
    .level_o (fifo_level)
  );

  xfer_lane_place u_place (
    .elem_i (head),
    .lane_i (wr_addr_o[1:0]),
    .size_i (size_q),
    .data_o (wr_data_o),
    .be_o   (wr_be_o)
  );

  assign busy_o = run_q;
  assign done_o = done_q;
endmodule

// File: rtl/xfer_engine_chk.sv
module xfer_engine_chk #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned LVL_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             rd_req_o,
  input logic             wr_req_o,
  input logic [3:0]       wr_be_o,
  input logic [LVL_W-1:0] fifo_level
);
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_level <= LVL_W'(DEPTH)); // R8

  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> fifo_level != '0); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !rd_req_o && !wr_req_o); // R1

  AST_BE_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> ($countones(wr_be_o) == 1 || wr_be_o == 4'b0011 ||
                  wr_be_o == 4'b1100 || wr_be_o == 4'b1111)); // R5

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9

  AST_DONE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(wr_req_o) || $past(start_i)); // R11

  AST_BUSY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !wr_req_o) |=> busy_o); // R10
endmodule

bind xfer_engine xfer_engine_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (.*);

// File: tb/tb_xfer_engine.sv
module tb_xfer_engine;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int CW = 8;
  localparam int DEPTH = 4;
  localparam int WD_LIMIT = 150000;

  logic          clk = 1'b0, rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] src_base_i = '0, dst_base_i = '0;
  logic [CW-1:0] count_i = '0;
  logic [1:0]    size_i = '0, src_step_i = '0, dst_step_i = '0;
  logic          rd_req_o, wr_req_o, busy_o, done_o;
  logic [AW-1:0] rd_addr_o, wr_addr_o;
  logic [31:0]   rd_data_i = '0, wr_data_o;
  logic [3:0]    wr_be_o;

  xfer_engine #(.AW(AW), .CW(CW), .DEPTH(DEPTH)) dut (.clk_i(clk), .*);

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] mem  [1024];
  logic [31:0] gold [1024];
  logic [31:0] gold_w [1024];
  int checks = 0, errors = 0, cyc = 0;
  int rd_n, wr_n, done_n, ahead_max;
  logic [AW-1:0] exp_rd, exp_wr;
  int m_sz, m_si, m_di;

  function automatic int step_b(int code);
    case (code) 0: return 1; 1: return 2; 2: return 4; default: return 0; endcase
  endfunction

  function automatic int nsz(int code);
    return (code == 3) ? 2 : code;
  endfunction

  function automatic logic [3:0] be_of(int sz, logic [AW-1:0] a);
    case (sz)
      0: return 4'b0001 << a[1:0];
      1: return a[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] get_elem(int sz, logic [AW-1:0] a);
    logic [31:0] w = gold[a[AW-1:2]];
    case (sz)
      0: return {24'd0, w[8*a[1:0] +: 8]};
      1: return {16'd0, a[1] ? w[31:16] : w[15:0]};
      default: return w;
    endcase
  endfunction

  task automatic put_elem(int sz, logic [AW-1:0] a, logic [31:0] e);
    case (sz)
      0: gold[a[AW-1:2]][8*a[1:0] +: 8] = e[7:0];
      1: gold[a[AW-1:2]][16*a[1] +: 16] = e[15:0];
      default: gold[a[AW-1:2]] = e;
    endcase
  endtask

  task automatic model(logic [AW-1:0] sb, logic [AW-1:0] db, int cnt, int sz, int si, int di);
    foreach (mem[i]) gold[i] = mem[i];
    for (int k = 0; k < cnt; k++)
      put_elem(nsz(sz), db + AW'(k * step_b(di)), get_elem(nsz(sz), sb + AW'(k * step_b(si))));
  endtask

  // memory model, port monitor, watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      check(1'b0, "WD", "watchdog expired", cyc, WD_LIMIT);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (rst_ni) begin
      if (rd_req_o) begin
        rd_data_i <= mem[rd_addr_o[AW-1:2]];
        check(rd_addr_o == exp_rd, "R2", "read address", rd_addr_o, exp_rd);
        exp_rd = exp_rd + AW'(step_b(m_si));
        rd_n++;
      end
      if (wr_req_o) begin
        check(wr_addr_o == exp_wr, "R2", "write address", wr_addr_o, exp_wr);
        check(wr_be_o == be_of(m_sz, wr_addr_o), "R5", "byte enables", wr_be_o, be_of(m_sz, wr_addr_o));
        for (int b = 0; b < 4; b++)
          if (wr_be_o[b]) mem[wr_addr_o[AW-1:2]][8*b +: 8] = wr_data_o[8*b +: 8];
        exp_wr = exp_wr + AW'(step_b(m_di));
        wr_n++;
      end
      if (rd_n - wr_n > ahead_max) ahead_max = rd_n - wr_n;
      if (done_o) done_n++;
    end
  end

  task automatic run_xfer(string tag, logic [AW-1:0] sb, logic [AW-1:0] db, int cnt,
                          int sz, int si, int di, bit poke);
    int waited = 0;
    int bad = 0, first = -1;
    model(sb, db, cnt, sz, si, di);
    exp_rd = sb; exp_wr = db;
    m_sz = nsz(sz); m_si = si; m_di = di;
    rd_n = 0; wr_n = 0; done_n = 0; ahead_max = 0;
    @(negedge clk);
    start_i = 1'b1; src_base_i = sb; dst_base_i = db; count_i = CW'(cnt);
    size_i = 2'(sz); src_step_i = 2'(si); dst_step_i = 2'(di);
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      @(negedge clk);
      check(busy_o == 1'b1, "R10", "busy before second start", busy_o, 1);
      start_i = 1'b1; dst_base_i = 12'h300; src_base_i = 12'h000; count_i = 8'd3;
      size_i = 2'd0; dst_step_i = 2'd3;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (!done_o && waited < 3000) begin
      @(negedge clk);
      waited++;
    end
    check(done_o == 1'b1, tag, "R9 done seen", done_o, 1);
    check(busy_o == 1'b0, tag, "R9 busy low with done", busy_o, 0);
    @(negedge clk);
    check(done_o == 1'b0 && done_n == 1, tag, "R9 single done pulse", done_n, 1);
    check(wr_n == cnt && rd_n == cnt, tag, "R9 access counts", wr_n, cnt);
    check(ahead_max <= DEPTH, tag, "R8 reads ahead of writes", ahead_max, DEPTH);
    foreach (mem[i]) if (mem[i] !== gold[i]) begin
      bad++;
      if (first < 0) first = i;
    end
    if (first < 0) first = 0;
    check(bad == 0, tag, $sformatf("memory image word %0d", first), mem[first], gold[first]);
    repeat (3) @(negedge clk);
    check(busy_o == 1'b0 && wr_n == cnt, tag, "R10 nothing after done", wr_n, cnt);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    foreach (mem[i]) mem[i] = $urandom;
    m_sz = 2; m_si = 2; m_di = 2; exp_rd = '0; exp_wr = '0;
    rd_n = 0; wr_n = 0; done_n = 0; ahead_max = 0;
    repeat (2) @(negedge clk);
    check({busy_o, done_o, rd_req_o, wr_req_o} == 4'b0, "R1", "outputs in reset",
          {busy_o, done_o, rd_req_o, wr_req_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check({busy_o, done_o, rd_req_o, wr_req_o} == 4'b0, "R1", "outputs idle after reset",
          {busy_o, done_o, rd_req_o, wr_req_o}, 0);

    run_xfer("R6", 12'h040, 12'h400, 12, 2, 2, 2, 0);
    // R7: half settings with twice the count reproduce the word image
    model(12'h080, 12'h480, 8, 2, 2, 2);
    foreach (gold[i]) gold_w[i] = gold[i];
    run_xfer("R7", 12'h080, 12'h480, 16, 1, 1, 1, 0);
    check(mem[12'h480 >> 2] == gold_w[12'h480 >> 2] && mem[(12'h480 >> 2) + 7] == gold_w[(12'h480 >> 2) + 7],
          "R7", "image equals word copy", mem[(12'h480 >> 2) + 7], gold_w[(12'h480 >> 2) + 7]);
    check(wr_n == 16, "R7", "twice the writes", wr_n, 16);
    run_xfer("R4", 12'h011, 12'h500, 9, 0, 0, 2, 0);   // byte unpack, odd start lane
    run_xfer("R4", 12'h020, 12'h542, 6, 1, 2, 1, 0);   // half pack from words
    run_xfer("R5", 12'h0a2, 12'h580, 5, 1, 1, 2, 0);   // half unpack into words
    run_xfer("R2", 12'h0c0, 12'h5c3, 7, 0, 0, 3, 0);   // fixed destination byte
    run_xfer("R3", 12'h0d0, 12'h600, 6, 3, 2, 2, 0);   // size code 3 acts as word
    run_xfer("R10", 12'h010, 12'h640, 14, 2, 2, 2, 1);
    run_xfer("R11", 12'h010, 12'h6c0, 0, 2, 2, 2, 0);
    run_xfer("R9", 12'h000, 12'h700, 1, 0, 0, 0, 0);

    for (int t = 0; t < 24; t++) begin
      int sz = $urandom_range(3);
      int si = $urandom_range(3);
      int di = $urandom_range(3);
      int eb = 1 << nsz(sz);
      int cnt = $urandom_range(16, 1);
      int off = eb * $urandom_range(4 / eb - 1);
      logic [AW-1:0] sb, db;
      if (step_b(si) != 0 && step_b(si) < eb) si = nsz(sz);
      if (step_b(di) != 0 && step_b(di) < eb) di = nsz(sz);
      sb = AW'(4 * $urandom_range(63) + off);
      db = AW'(12'h400 + 4 * $urandom_range(127) + eb * $urandom_range(4 / eb - 1));
      run_xfer("R8", sb, db, cnt, sz, si, di, 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule